// File: doc/BRIEF.md
# Clock-Stop Serial Master

This block is a single-word synchronous serial master. It derives a serial clock from the system clock by a programmable divide value. The clock rests low, and it runs only while the active-low select holds a transfer open. The high and low phases differ by one system cycle when the divide value is even and are equal when it is odd.

A transfer begins with a one-cycle start strobe. The strobe captures the transmit byte and the divide value. Select falls first. The data line is enabled a high-phase time later, and the first rising clock edge comes a full serial period after select falls. Outgoing bits change on falling edges, most significant bit first. Incoming bits are captured on rising edges. After the final falling edge the data line is released, and select stays low for one more low phase. Select then rises, and the received byte is presented with a one-cycle done pulse.

Top module: `spi_cs_master`

## Requirements
- R1: With D = the divide value captured at start (and taken as 1 when it is 0), each serial clock period during a transfer lasts D+1 system cycles.
- R2: For even D the clock is high for D/2+1 cycles and low for D/2 cycles.
- R3: For odd D the high and low phases each last (D+1)/2 cycles.
- R4: A divide value of 0 gives the same timing as a divide value of 1.
- R5: The serial clock is low whenever select is high, and it stays low between transfers.
- R6: Select goes low on the cycle after an accepted start, exactly D+1 cycles before the first rising clock edge.
- R7: The output enable rises, with the MSB on the data line, one high-phase time after select falls. Each later bit appears on a falling clock edge, MSB first.
- R8: The serial input is sampled when the clock rises. The first bit sampled becomes bit 7 of the received byte.
- R9: Select rises one low-phase time after the eighth falling edge. In that same cycle done pulses for one cycle and the received byte appears on the receive output.
- R10: The output enable drops on the eighth falling clock edge and stays low until the next transfer.
- R11: A start strobe given while a transfer is in progress has no effect on the ongoing transfer. The divide value and transmit byte present with it are also ignored.
- R12: After reset, select is high, the clock is low, the output enable is low and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Clock divide value, captured at start |
| tx_data_i | input | WORD_W | Byte to send, captured at start |
| start_i | input | 1 | One-cycle start strobe |
| rx_data_o | output | WORD_W | Received byte, updated with done |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for the serial data pin |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Active-low select |

## Verification
The properties assume that start is a single-cycle pulse. They also assume that the serial input holds steady around each rising clock edge. The bench's slave model changes its output only on falling clock edges, and each start is driven for one cycle. While a transfer runs, the bench changes the divide value and the transmit byte. The properties need only hold on the captured copies, so the checks still apply.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_H,
    ST_LEAD_L,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } spi_st_e;
endpackage

// File: rtl/spi_phase_calc.sv
module spi_phase_calc #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] hi_len_o,
  output logic [DIV_W-1:0] lo_len_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic [DIV_W-1:0] d_eff;
  logic [DIV_W-1:0] half;

  always_comb begin
    d_eff    = (div_i == '0) ? ONE : div_i;
    half     = d_eff >> 1;
    hi_len_o = half + ONE;
    lo_len_o = d_eff[0] ? half + ONE : half;
  end
endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic [WORD_W-1:0] par_o
);
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= data_i;
      else if (shift_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      if (sample_i)     rx_q <= {rx_q[WORD_W-2:0], ser_i};
    end
  end

  assign ser_o = tx_q[WORD_W-1];
  assign par_o = rx_q;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              start_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              ss_no
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  spi_st_e          st_q;
  logic [DIV_W-1:0] cnt_q, hi_q, lo_q, hi_c, lo_c;
  logic [BIT_W-1:0] bit_q;
  logic [WORD_W-1:0] rx_par;
  logic             cnt_end, load, shift, sample;

  spi_phase_calc #(.DIV_W(DIV_W)) u_calc (
    .div_i    (div_i),
    .hi_len_o (hi_c),
    .lo_len_o (lo_c)
  );

  assign cnt_end = (cnt_q == '0);
  assign load    = (st_q == ST_IDLE) && start_i;
  assign shift   = (st_q == ST_HIGH) && cnt_end && (bit_q != LAST_BIT);
  assign sample  = ((st_q == ST_LEAD_L) || (st_q == ST_LOW)) && cnt_end;

  spi_shreg #(.WORD_W(WORD_W)) u_sh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .data_i   (tx_data_i),
    .shift_i  (shift),
    .sample_i (sample),
    .ser_i    (miso_i),
    .ser_o    (mosi_o),
    .par_o    (rx_par)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      hi_q      <= ONE;
      lo_q      <= ONE;
      bit_q     <= '0;
      sclk_o    <= 1'b0;
      ss_no     <= 1'b1;
      mosi_oe_o <= 1'b0;
      done_o    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          hi_q  <= hi_c;
          lo_q  <= lo_c;
          cnt_q <= hi_c - ONE;
          bit_q <= '0;
          ss_no <= 1'b0;
          st_q  <= ST_LEAD_H;
        end
        ST_LEAD_H: if (cnt_end) begin
          mosi_oe_o <= 1'b1;
          cnt_q     <= lo_q - ONE;
          st_q      <= ST_LEAD_L;
        end else cnt_q <= cnt_q - ONE;
        ST_LEAD_L, ST_LOW: if (cnt_end) begin
          sclk_o <= 1'b1;
          cnt_q  <= hi_q - ONE;
          st_q   <= ST_HIGH;
        end else cnt_q <= cnt_q - ONE;
        ST_HIGH: if (cnt_end) begin
          sclk_o <= 1'b0;
          cnt_q  <= lo_q - ONE;
          if (bit_q == LAST_BIT) begin
            mosi_oe_o <= 1'b0;
            st_q      <= ST_TAIL;
          end else begin
            bit_q <= bit_q + BIT_ONE;
            st_q  <= ST_LOW;
          end
        end else cnt_q <= cnt_q - ONE;
        ST_TAIL: if (cnt_end) begin
          ss_no     <= 1'b1;
          done_o    <= 1'b1;
          rx_data_o <= rx_par;
          st_q      <= ST_IDLE;
        end else cnt_q <= cnt_q - ONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic ss_no,
  input logic mosi_o,
  input logic mosi_oe_o,
  input logic done_o
);
  // R5
  a_r5_clock_only_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o);
  // R10
  a_r10_oe_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mosi_oe_o |-> !ss_no);
  // R10
  a_r10_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mosi_oe_o) |-> $fell(sclk_o));
  // R9
  a_r9_done_with_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(ss_no));
  // R7
  a_r7_data_before_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> mosi_oe_o);
  // R7
  a_r7_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  // R6
  a_r6_quiet_select_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_no) |-> (!sclk_o && !mosi_oe_o));
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sclk_o    (sclk_o),
  .ss_no     (ss_no),
  .mosi_o    (mosi_o),
  .mosi_oe_o (mosi_oe_o),
  .done_o    (done_o)
);

// File: tb/sim_spi_cs_master.sv
`timescale 1ns/1ps
module sim_spi_cs_master;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd1;
  logic [7:0] tx = 8'h00;
  logic       start = 1'b0;
  logic [7:0] rx_data;
  logic       done, sclk, mosi, mosi_oe, ss_n;
  logic       miso;

  int n_total = 0;
  int n_bad   = 0;
  bit finished = 1'b0;

  logic [7:0] s_word = 8'h00;
  logic [7:0] s_sh   = 8'h00;
  logic [7:0] s_rx   = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cs_master u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .div_i     (div),
    .tx_data_i (tx),
    .start_i   (start),
    .rx_data_o (rx_data),
    .done_o    (done),
    .sclk_o    (sclk),
    .mosi_o    (mosi),
    .mosi_oe_o (mosi_oe),
    .miso_i    (miso),
    .ss_no     (ss_n)
  );

  // loopback slave: loads at select fall, shifts out on falling clock, captures on rising
  always @(negedge ss_n) s_sh = s_word;
  always @(negedge sclk) if (!ss_n) s_sh = {s_sh[6:0], 1'b0};
  always @(posedge sclk) s_rx = {s_rx[6:0], mosi};
  assign miso = s_sh[7];

  logic [3:0] qv[$];
  string      qt[$];

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(int n, logic [3:0] v, string tag);
    for (int k = 0; k < n; k++) begin
      qv.push_back(v);
      qt.push_back(tag);
    end
  endtask

  task automatic run_xfer(logic [7:0] d_in, logic [7:0] t_in, logic [7:0] s_in, bit glitch);
    int d, h, l;
    string th;
    logic [3:0] act;
    d  = (d_in == 0) ? 1 : int'(d_in);
    h  = d / 2 + 1;
    l  = (d % 2 == 1) ? h : d / 2;
    th = (d % 2 == 0) ? "R2" : "R3";
    if (d_in == 0) th = {"R4/", th};
    qv.delete();
    qt.delete();
    // entry {ss, sclk, oe, mosi when oe}
    push(h, 4'b0000, glitch ? "R11" : "R7");
    push(l, {3'b001, t_in[7]}, glitch ? "R11" : "R6");
    for (int b = 0; b < 8; b++) begin
      push(h, {3'b011, t_in[7-b]}, glitch ? "R11" : th);
      if (b < 7) push(l, {3'b001, t_in[6-b]}, glitch ? "R11" : "R1");
    end
    push(l, 4'b0000, glitch ? "R11" : "R9/R10");

    @(negedge clk);
    div    = d_in;
    tx     = t_in;
    s_word = s_in;
    start  = 1'b1;
    for (int i = 0; i < qv.size(); i++) begin
      @(negedge clk);
      start = glitch && (i == 5);
      if (glitch && i == 5) begin
        div = 8'd3;
        tx  = ~t_in;
      end
      act = {ss_n, sclk, mosi_oe, mosi_oe ? mosi : 1'b0};
      chk(qt[i], {4'h0, act}, {4'h0, qv[i]});
    end
    @(negedge clk);
    chk("R9 select released", {7'd0, ss_n}, 8'd1);
    chk("R9 done pulse", {7'd0, done}, 8'd1);
    chk("R8 received byte", rx_data, s_in);
    chk("R7 slave saw byte", s_rx, t_in);
    @(negedge clk);
    chk("R9 done one cycle", {7'd0, done}, 8'd0);
    chk("R5 idle clock low", {6'd0, sclk, mosi_oe}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {4'd0, ss_n, sclk, mosi_oe, done}, 8'b0000_1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after release", {4'd0, ss_n, sclk, mosi_oe, done}, 8'b0000_1000);
    run_xfer(8'd1,   8'hA5, 8'h3C, 1'b0);
    run_xfer(8'd2,   8'h5A, 8'hC3, 1'b0);
    run_xfer(8'd3,   8'hF0, 8'h0F, 1'b0);
    run_xfer(8'd4,   8'h81, 8'h7E, 1'b0);
    run_xfer(8'd0,   8'h96, 8'h69, 1'b0);
    run_xfer(8'd7,   8'h00, 8'hFF, 1'b0);
    run_xfer(8'd6,   8'hC5, 8'h9A, 1'b1);
    run_xfer(8'd255, 8'h3E, 8'hE3, 1'b0);
    run_xfer(8'd8,   8'hFF, 8'h01, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 clock parked", {6'd0, ss_n, sclk}, 8'b10);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule